// File: doc/BRIEF.md
# FIFO Phase Surveillance Controller

This controller watches where the read counter of an eight-entry FIFO sits relative to the write side. Every clock it takes a raw 3-bit read-position sample. It feeds the sample into an exponential averaging filter whose strength is programmable. At the end of each fixed-length measurement window it publishes the integer part of the averaged position as status.

The published position is compared against an edge window near either end of the FIFO. A hit sets an error status bit. With surveillance running and the interrupt enabled, a hit also raises a sticky interrupt. With surveillance running and the interrupt disabled, an auto mode can retune the 2-bit readout offset so that the averaged position moves toward the FIFO centre. Outside surveillance, the controller finishes the window it is in and then holds its status.

Top module: `fifo_phase_monitor`

## Requirements
- R1: After reset the outputs read: pos_o = 0, err_o = 0, valid_o = 0, chg_o = 0, irq_o = 0, read_ofs_o = 00 and ofs_rd_o = 00.
- R2: Each sample taken moves the filter state A (3 integer bits, 12 fraction bits) to A + ((s - floor(A)) * 2^12) >> L. Here the shift is arithmetic, L = flt_len_i, and any L above 12 acts as 12. With L = 0 the integer part equals the latest sample.
- R3: A measurement window spans 16 consecutive samples. pos_o, err_o and chg_o change only at the end of a window, where pos_o takes floor(A). valid_o rises at the end of the first window after reset and then stays at 1.
- R4: The edge window is {0, 7} when thr_sel_i = 0 and {0, 1, 6, 7} when thr_sel_i = 1.
- R5: At each window end, err_o is set to 1 if the new position lies in the edge window and to 0 if it does not.
- R6: When a window ends with surv_en_i = 0, no further samples are taken and the status is frozen. A new window starts one cycle after surv_en_i returns to 1. The first window after reset runs regardless of surv_en_i.
- R7: irq_o becomes 1 at a window end where surv_en_i = 1, irq_en_i = 1 and the new position is in the edge window. It then holds until an irq_clr_i pulse. A new set in the same cycle as a clear wins.
- R8: chg_o is updated at each window end. It becomes 1 only if surv_en_i = 1, valid_o was already 1, and {err, pos} differs from its previous value; otherwise it becomes 0.
- R9: read_ofs_o resets to 00. ofs_wr_i loads ofs_wdata_i into it on the next edge, and a write wins over an auto update in the same cycle.
- R10: Auto mode is active when auto_en_i = 1, surv_en_i = 1 and irq_en_i = 0. At each window end in auto mode, read_ofs_o is updated from its current value o and the new position p. The new value is o + (3 - p) if p < 3, o - (p - 4) if p > 4, and o otherwise, clamped to 0..3.
- R11: ofs_rd_o shows the offset captured when the interrupt was last set (reset 00) while surv_en_i = 1 and auto mode is inactive. Otherwise it shows read_ofs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 3 | Raw FIFO read position, one sample per cycle |
| surv_en_i | input | 1 | Surveillance mode: continuous measurement windows |
| auto_en_i | input | 1 | Auto offset correction request |
| irq_en_i | input | 1 | Interrupt enable |
| flt_len_i | input | 4 | Filter length L (above 12 acts as 12) |
| thr_sel_i | input | 1 | Edge window select: 0 narrow, 1 wide |
| ofs_wr_i | input | 1 | Offset write strobe |
| ofs_wdata_i | input | 2 | Offset write value |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| pos_o | output | 3 | Averaged read position status |
| err_o | output | 1 | Position in edge window at last window end |
| valid_o | output | 1 | Status valid since reset |
| chg_o | output | 1 | Status changed at last window end |
| ofs_rd_o | output | 2 | Offset status view (captured or live) |
| read_ofs_o | output | 2 | Readout offset applied to the FIFO read counter |
| irq_o | output | 1 | Sticky interrupt |

## Verification
A corrupted filter fraction stays hidden until it carries into the integer part. It then shows on pos_o at a window end, possibly several windows later with long filter lengths. For this reason every output is compared on every cycle against a bench model through thousands of random cycles. A wrong window counter or wrong stop logic shows within at most 16 cycles: status moves at the wrong edge, or keeps moving after surveillance is turned off. A wrong window test, interrupt set or offset update shows at the first window end that meets the triggering position, through err_o, irq_o or read_ofs_o.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned POS_W   = 3;
  localparam int unsigned POS_MAX = (1 << POS_W) - 1;
  localparam int unsigned CTR_LO  = POS_MAX / 2;
  localparam int unsigned CTR_HI  = CTR_LO + 1;

  typedef struct packed {
    logic             err;
    logic [POS_W-1:0] pos;
  } fpm_status_t;
endpackage

// File: rtl/fpm_filter.sv
module fpm_filter #(
  parameter int unsigned POS_W   = 3,
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned LEN_MAX = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [POS_W-1:0] sample_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [POS_W-1:0] pos_nxt_o
);
  localparam int unsigned AW = POS_W + FRAC_W;
  localparam int unsigned DW = AW + 1;

  logic        [AW-1:0]    acc_q, acc_d;
  logic signed [POS_W:0]   delta;
  logic signed [DW-1:0]    scaled, step, sum;
  logic        [LEN_W-1:0] shamt;

  always_comb begin
    delta  = $signed({1'b0, sample_i}) - $signed({1'b0, acc_q[AW-1:FRAC_W]});
    scaled = {delta, {FRAC_W{1'b0}}};
    shamt  = (len_i > LEN_W'(LEN_MAX)) ? LEN_W'(LEN_MAX) : len_i;
    step   = scaled >>> shamt;
    sum    = $signed({1'b0, acc_q}) + step;
    acc_d  = sum[AW-1:0];
  end

  assign pos_nxt_o = acc_d[AW-1:FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end
endmodule

// File: rtl/fpm_meas_timer.sv
module fpm_meas_timer #(
  parameter int unsigned MEAS_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = (MEAS_LEN > 1) ? $clog2(MEAS_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MEAS_LEN - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign active_o = busy_q;
  assign done_o   = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;  // first window runs unconditionally
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      if (done_o) busy_q <= run_i;
    end else if (run_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/fpm_offset_ctrl.sv
module fpm_offset_ctrl #(
  parameter int unsigned POS_W  = 3,
  parameter int unsigned OFS_W  = 2,
  parameter int unsigned CTR_LO = 3,
  parameter int unsigned CTR_HI = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] wdata_i,
  input  logic             upd_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             snap_i,
  input  logic             show_snap_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] ofs_rd_o
);
  localparam int OMAX = (1 << OFS_W) - 1;

  logic [OFS_W-1:0] ofs_q, snap_q, tgt;
  int p, o, t;

  always_comb begin
    p = int'(pos_i);
    o = int'(ofs_q);
    if (p < int'(CTR_LO))      t = o + (int'(CTR_LO) - p);
    else if (p > int'(CTR_HI)) t = o - (p - int'(CTR_HI));
    else                       t = o;
    if (t < 0)    t = 0;
    if (t > OMAX) t = OMAX;
    tgt = OFS_W'(t);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      snap_q <= '0;
    end else begin
      if (wr_i)       ofs_q <= wdata_i;
      else if (upd_i) ofs_q <= tgt;
      if (snap_i)     snap_q <= ofs_q;
    end
  end

  assign ofs_o    = ofs_q;
  assign ofs_rd_o = show_snap_i ? snap_q : ofs_q;
endmodule

// File: rtl/fifo_phase_monitor.sv
module fifo_phase_monitor
  import fpm_pkg::*;
#(
  parameter int unsigned FRAC_W   = 12,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned LEN_MAX  = 12,
  parameter int unsigned MEAS_LEN = 16,
  parameter int unsigned OFS_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] sample_i,
  input  logic             surv_en_i,
  input  logic             auto_en_i,
  input  logic             irq_en_i,
  input  logic [LEN_W-1:0] flt_len_i,
  input  logic             thr_sel_i,
  input  logic             ofs_wr_i,
  input  logic [OFS_W-1:0] ofs_wdata_i,
  input  logic             irq_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             err_o,
  output logic             valid_o,
  output logic             chg_o,
  output logic [OFS_W-1:0] ofs_rd_o,
  output logic [OFS_W-1:0] read_ofs_o,
  output logic             irq_o
);
  logic             meas_active, meas_done;
  logic [POS_W-1:0] pos_nxt;
  logic             hit, auto_act, irq_set;
  fpm_status_t      stat_q, stat_d;
  logic             valid_q, chg_q, irq_q;

  fpm_meas_timer #(.MEAS_LEN(MEAS_LEN)) u_timer (
    .clk_i, .rst_ni, .run_i(surv_en_i), .active_o(meas_active), .done_o(meas_done)
  );

  fpm_filter #(.POS_W(POS_W), .FRAC_W(FRAC_W), .LEN_W(LEN_W), .LEN_MAX(LEN_MAX)) u_filter (
    .clk_i, .rst_ni, .en_i(meas_active), .sample_i, .len_i(flt_len_i), .pos_nxt_o(pos_nxt)
  );

  // edge window: outer pair always, inner pair when wide
  always_comb begin
    hit = (pos_nxt == '0) || (pos_nxt == POS_W'(POS_MAX));
    if (thr_sel_i)
      hit = hit || (pos_nxt == POS_W'(1)) || (pos_nxt == POS_W'(POS_MAX - 1));
    stat_d.err = hit;
    stat_d.pos = pos_nxt;
  end

  assign auto_act = auto_en_i && surv_en_i && !irq_en_i;
  assign irq_set  = meas_done && surv_en_i && irq_en_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      valid_q <= 1'b0;
      chg_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (meas_done) begin
        stat_q  <= stat_d;
        valid_q <= 1'b1;
        chg_q   <= surv_en_i && valid_q && (stat_d != stat_q);
      end
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  fpm_offset_ctrl #(.POS_W(POS_W), .OFS_W(OFS_W), .CTR_LO(CTR_LO), .CTR_HI(CTR_HI)) u_ofs (
    .clk_i, .rst_ni,
    .wr_i(ofs_wr_i), .wdata_i(ofs_wdata_i),
    .upd_i(meas_done && auto_act), .pos_i(pos_nxt),
    .snap_i(irq_set), .show_snap_i(surv_en_i && !auto_act),
    .ofs_o(read_ofs_o), .ofs_rd_o(ofs_rd_o)
  );

  assign pos_o   = stat_q.pos;
  assign err_o   = stat_q.err;
  assign valid_o = valid_q;
  assign chg_o   = chg_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int unsigned OFS_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             surv_en_i,
  input logic             auto_en_i,
  input logic             irq_en_i,
  input logic             irq_clr_i,
  input logic             ofs_wr_i,
  input logic [OFS_W-1:0] ofs_wdata_i,
  input logic [2:0]       pos_o,
  input logic             err_o,
  input logic             valid_o,
  input logic             chg_o,
  input logic             irq_o,
  input logic [OFS_W-1:0] read_ofs_o
);
  a_r3_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(pos_o));
  a_r3_valid_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  a_r5_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(err_o));
  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);
  a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i && surv_en_i && irq_en_i));
  a_r8_chg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_o) |-> $past(done_i && surv_en_i));
  a_r9_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_wr_i |=> read_ofs_o == $past(ofs_wdata_i));
  a_r10_ofs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(read_ofs_o) |-> $past(ofs_wr_i) || $past(done_i && auto_en_i && surv_en_i && !irq_en_i));
endmodule

bind fifo_phase_monitor fpm_checker #(.OFS_W(OFS_W)) u_chk (
  .clk_i, .rst_ni, .done_i(meas_done), .surv_en_i, .auto_en_i, .irq_en_i, .irq_clr_i,
  .ofs_wr_i, .ofs_wdata_i, .pos_o, .err_o, .valid_o, .chg_o, .irq_o, .read_ofs_o
);

// File: tb/fifo_phase_monitor_tb.sv
`timescale 1ns/1ps
module fifo_phase_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sample_i = '0;
  logic       surv_en_i = 1'b0, auto_en_i = 1'b0, irq_en_i = 1'b0;
  logic [3:0] flt_len_i = '0;
  logic       thr_sel_i = 1'b0, ofs_wr_i = 1'b0, irq_clr_i = 1'b0;
  logic [1:0] ofs_wdata_i = '0;
  logic [2:0] pos_o;
  logic       err_o, valid_o, chg_o, irq_o;
  logic [1:0] ofs_rd_o, read_ofs_o;

  always #10 clk = ~clk;

  fifo_phase_monitor u_dut (
    .clk_i(clk), .rst_ni, .sample_i, .surv_en_i, .auto_en_i, .irq_en_i, .flt_len_i,
    .thr_sel_i, .ofs_wr_i, .ofs_wdata_i, .irq_clr_i, .pos_o, .err_o, .valid_o,
    .chg_o, .ofs_rd_o, .read_ofs_o, .irq_o
  );

  int n_chk = 0, n_bad = 0;
  int m_acc, m_cnt, m_pos, m_err, m_ofs, m_snap;
  bit m_busy, m_valid, m_chg, m_irq;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit in_window(int p, bit wide);
    return (p == 0) || (p == 7) || (wide && (p == 1 || p == 6));
  endfunction

  function automatic int auto_target(int o, int p);
    int t;
    if (p < 3)      t = o + (3 - p);
    else if (p > 4) t = o - (p - 4);
    else            t = o;
    if (t < 0) t = 0;
    if (t > 3) t = 3;
    return t;
  endfunction

  task automatic model_reset();
    m_acc = 0; m_cnt = 0; m_pos = 0; m_err = 0; m_ofs = 0; m_snap = 0;
    m_busy = 1; m_valid = 0; m_chg = 0; m_irq = 0;
  endtask

  // applied right after a rising edge with the inputs that edge saw
  task automatic model_step();
    bit done = 0, hit = 0, irq_set;
    int np = m_pos, l, d, oldofs = m_ofs;
    if (m_busy) begin
      l = (int'(flt_len_i) > 12) ? 12 : int'(flt_len_i);
      d = int'(sample_i) - (m_acc >> 12);
      m_acc = m_acc + ((d * 4096) >>> l);
      done = (m_cnt == 15);
      m_cnt = (m_cnt + 1) % 16;
      if (done) begin
        np = m_acc >> 12;
        hit = in_window(np, thr_sel_i);
        m_chg = surv_en_i && m_valid && ((np != m_pos) || (int'(hit) != m_err));
        m_pos = np; m_err = int'(hit); m_valid = 1;
        m_busy = surv_en_i;
      end
    end else if (surv_en_i) begin
      m_busy = 1; m_cnt = 0;
    end
    irq_set = done && surv_en_i && irq_en_i && hit;
    if (irq_set) begin m_irq = 1; m_snap = oldofs; end
    else if (irq_clr_i) m_irq = 0;
    if (ofs_wr_i) m_ofs = int'(ofs_wdata_i);
    else if (done && auto_en_i && surv_en_i && !irq_en_i) m_ofs = auto_target(oldofs, np);
  endtask

  task automatic compare_all(string pfx);
    bit aut = auto_en_i && surv_en_i && !irq_en_i;
    chk({pfx, " R3 pos"},        int'(pos_o), m_pos);
    chk({pfx, " R5 err"},        int'(err_o), m_err);
    chk({pfx, " R3 valid"},      int'(valid_o), int'(m_valid));
    chk({pfx, " R8 chg"},        int'(chg_o), int'(m_chg));
    chk({pfx, " R7 irq"},        int'(irq_o), int'(m_irq));
    chk({pfx, " R10 read_ofs"},  int'(read_ofs_o), m_ofs);
    chk({pfx, " R11 ofs_rd"},    int'(ofs_rd_o), (surv_en_i && !aut) ? m_snap : m_ofs);
  endtask

  task automatic cycle(string pfx);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(pfx);
  endtask

  task automatic run(string pfx, int n);
    for (int i = 0; i < n; i++) cycle(pfx);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R3 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int frozen;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    compare_all("R1 reset");
    chk("R1 pos",  int'(pos_o), 0);
    chk("R1 ofs",  int'(read_ofs_o), 0);

    // R2 L=0: integer tracks sample; R4/R5/R7 narrow window hit at 7
    surv_en_i = 1; irq_en_i = 1; flt_len_i = 0; sample_i = 7;
    run("R2 track", 16);
    chk("R2 pos follows sample", int'(pos_o), 7);
    chk("R3 valid after first window", int'(valid_o), 1);
    chk("R7 irq set at edge", int'(irq_o), 1);
    irq_clr_i = 1; cycle("R7 clear"); irq_clr_i = 0;
    chk("R7 irq cleared", int'(irq_o), 0);

    // R4 wide window at 6, narrow window misses 6
    sample_i = 6; thr_sel_i = 0; run("R4 narrow", 32);
    chk("R4 narrow 6 no err", int'(err_o), 0);
    thr_sel_i = 1; run("R4 wide", 16);
    chk("R4 wide 6 err", int'(err_o), 1);

    // R9 write, R11 captured offset shown in surveillance
    ofs_wr_i = 1; ofs_wdata_i = 2; cycle("R9 write"); ofs_wr_i = 0;
    chk("R9 read_ofs written", int'(read_ofs_o), 2);
    sample_i = 3; thr_sel_i = 0; run("R2 settle", 32);

    // R2 clip: L=15 behaves as 12
    flt_len_i = 15; sample_i = 0; run("R2 clip", 48);

    // R6 surveillance off: finish window then freeze
    surv_en_i = 0; run("R6 stop", 16);
    frozen = int'(pos_o);
    sample_i = 7; flt_len_i = 0; run("R6 frozen", 40);
    chk("R6 pos frozen", int'(pos_o), frozen);
    surv_en_i = 1; run("R6 restart", 20);

    // R10 auto mode pulls offset up when position low
    irq_en_i = 0; auto_en_i = 1; flt_len_i = 0; sample_i = 0;
    ofs_wr_i = 1; ofs_wdata_i = 0; cycle("R10 preset"); ofs_wr_i = 0;
    run("R10 auto", 40);
    chk("R10 offset clamped high", int'(read_ofs_o), 3);
    sample_i = 7; run("R10 auto down", 32);
    chk("R10 offset clamped low", int'(read_ofs_o), 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 64 == 0) begin
        surv_en_i = ($urandom % 4) != 0;
        auto_en_i = $urandom % 2;
        irq_en_i  = $urandom % 2;
        flt_len_i = 4'($urandom % 16);
        thr_sel_i = $urandom % 2;
      end
      sample_i    = 3'($urandom % 8);
      irq_clr_i   = ($urandom % 8) == 0;
      ofs_wr_i    = ($urandom % 32) == 0;
      ofs_wdata_i = 2'($urandom % 4);
      cycle("rand");
    end

    summary();
    $finish;
  end
endmodule